// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block sits between a host-side configuration access port and the transmit side of a PCIe root port. Each host request names a target bus, a device/function, a register address, an access size of one, two or four bytes, a direction and, for writes, the data. The block first decides whether the target may be reached at all. It checks for the hidden base-address register of the root port itself. It checks whether the link has trained when the target lies beyond the root bus. It also enforces the single-slot topology next to the root port. An access that is refused completes at once with a status code and sends nothing.

An access that is admitted becomes a three-dword configuration request header. The header carries type 0 or type 1 coding, the requester ID, a tag and byte enables. It is streamed as 64-bit beats marked with start and end flags, packed according to quadword alignment. The block keeps its own copy of the root bus number and refreshes it when a write to the root port's primary bus register has been sent. Completions are handled elsewhere; the status returned for an admitted access reports only that the request went out.

Top module: `cfg_tlp_builder`

## Requirements
- R1: After reset, `req_ready` is 1, `beat_valid` and `resp_valid` are 0, and `root_bus` equals the parameter `ROOT_INIT` (default 0).
- R2: The low half of the first beat is header dword 0: bits 31:24 hold the format/type byte and bits 23:0 hold the value 1. The format/type byte is 0x04 for a read and 0x44 for a write when the target bus equals `root_bus`. It is 0x05 for a read and 0x45 for a write otherwise.
- R3: The high half of the first beat is header dword 1: bits 31:24 are `root_bus`, bits 23:16 are zero, bits 15:8 are the tag (0x1D for reads, 0x10 for writes), bits 7:4 are zero and bits 3:0 are the byte enables.
- R4: Header dword 2 holds the bus in bits 31:24 and the device/function in bits 23:16. Bits 15:0 hold the register address zero-extended, with bits 1:0 forced to zero.
- R5: `req_size` 0 means one byte, 1 means two bytes, 2 or 3 mean four bytes. The byte enables are 4'b0001 or 4'b0011 shifted left by addr[1:0] (kept to 4 bits), or 4'hF for four bytes. Write data is masked to the size and shifted left by 8*addr[1:0] (kept to 32 bits). Read data is zero.
- R6: A write with addr[2:0] == 0 is sent as three beats: {dw1,dw0} with start, then {0,dw2} with no flags, then {0,data} with end.
- R7: Every other admitted request is sent as two beats: {dw1,dw0} with start and {data,dw2} with end.
- R8: A request to bus `root_bus`, device/function 0, register address exactly 0x10 is refused with status 2 and read data 0, and sends no beat.
- R9: A request to any bus other than `root_bus` while `link_state` is not 0x0F is refused with status 1 and sends no beat.
- R10: A request to a device number (devfn[7:3]) above 0 is refused with status 1 when its bus is `root_bus`, or when its `req_prim_bus` is `root_bus`. A refused read returns 0xFFFFFFFF; a refused write returns 0.
- R11: `root_bus` changes only in the cycle after the end beat of a write to bus `root_bus` at address exactly 0x18, and then takes the low byte of the shifted write data.
- R12: A request is accepted only when `req_ready` is 1, which holds only while no packet is in flight. A beat holds its data and flags until `beat_ready` takes it. `resp_valid` pulses for one cycle with status 0 after the end beat is taken, or the cycle after a refused request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_state | input | 5 | Current link-training state; 0x0F means link up |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, else 4 bytes) |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (7:3) and function (2:0) |
| req_prim_bus | input | 8 | Primary bus number of the target's bus |
| req_addr | input | ADDR_W | Register byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Beat taken |
| beat_data | output | 64 | Beat payload |
| beat_sop | output | 1 | First beat of a packet |
| beat_eop | output | 1 | Last beat of a packet |
| resp_valid | output | 1 | One-cycle completion pulse for a request |
| resp_status | output | 2 | 0 sent, 1 device not reachable, 2 bad register |
| resp_rdata | output | 32 | Data returned for refused requests |
| root_bus | output | 8 | Local root bus number |

## Verification
A request is taken at the clock edge where `req_valid` and `req_ready` are both high. The first beat is visible just after that same edge. A refused request shows its `resp_valid` pulse just after that edge and never raises `beat_valid`. Every following beat appears just after the edge that took the previous one. The response pulse, the root bus update and the return of `req_ready` all appear together just after the edge that takes the end beat. The bench drives and samples one time step after each rising edge and compares each expected item exactly there, including during stalls made by holding `beat_ready` low.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

  localparam logic [4:0] LINK_UP_STATE  = 5'h0F;
  localparam int         HIDDEN_BAR_OFS = 'h10;
  localparam int         PRIM_BUS_OFS   = 'h18;
  localparam logic [7:0] TAG_RD         = 8'h1D;
  localparam logic [7:0] TAG_WR         = 8'h10;
  localparam logic [7:0] FMT_CFG_BASE   = 8'h04;

  typedef enum logic [1:0] {
    ST_SENT      = 2'd0,
    ST_NO_DEVICE = 2'd1,
    ST_BAD_REG   = 2'd2
  } cfg_status_e;

  typedef struct packed {
    logic [31:0] dw0;
    logic [31:0] dw1;
    logic [31:0] dw2;
    logic [31:0] data;
    logic        three_beat;
    logic        root_upd;
  } cfg_pkt_t;

endpackage

// File: rtl/cfg_access_filter.sv
module cfg_access_filter
  import cfg_tlp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [7:0]        bus,
  input  logic [7:0]        devfn,
  input  logic [7:0]        prim_bus,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        root_bus,
  input  logic [4:0]        link_state,
  output cfg_status_e       status
);

  logic on_root;
  logic dev_nonzero;

  assign on_root     = (bus == root_bus);
  assign dev_nonzero = (devfn[7:3] != 5'd0);

  always_comb begin
    status = ST_SENT;
    if (on_root && (devfn == 8'd0) && (addr == ADDR_W'(HIDDEN_BAR_OFS)))
      status = ST_BAD_REG;
    else if (!on_root && (link_state != LINK_UP_STATE))
      status = ST_NO_DEVICE;
    else if (on_root && dev_nonzero)
      status = ST_NO_DEVICE;
    else if ((prim_bus == root_bus) && dev_nonzero)
      status = ST_NO_DEVICE;
  end

endmodule

// File: rtl/cfg_header_former.sv
module cfg_header_former
  import cfg_tlp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [7:0]        bus,
  input  logic [7:0]        devfn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  input  logic [31:0]       wdata,
  input  logic [7:0]        root_bus,
  output logic [3:0]        byte_en,
  output cfg_pkt_t          pkt
);

  localparam int OFS_W = 16;

  logic [1:0]       lane;
  logic [4:0]       shamt;
  logic [31:0]      masked;
  logic [31:0]      shifted;
  logic [7:0]       fmt;
  logic [OFS_W-1:0] ofs;

  assign lane  = addr[1:0];
  assign shamt = {lane, 3'b000};

  always_comb begin
    case (size)
      2'd0: begin
        byte_en = 4'(4'b0001 << lane);
        masked  = {24'd0, wdata[7:0]};
      end
      2'd1: begin
        byte_en = 4'(4'b0011 << lane);
        masked  = {16'd0, wdata[15:0]};
      end
      default: begin
        byte_en = 4'hF;
        masked  = wdata;
      end
    endcase
  end

  assign shifted = write ? (masked << shamt) : 32'd0;
  assign fmt     = FMT_CFG_BASE | {1'b0, write, 5'd0, (bus != root_bus)};
  assign ofs     = OFS_W'(addr) & 16'hFFFC;

  always_comb begin
    pkt.dw0        = {fmt, 24'd1};
    pkt.dw1        = {root_bus, 8'd0, (write ? TAG_WR : TAG_RD), 4'd0, byte_en};
    pkt.dw2        = {bus, devfn, ofs};
    pkt.data       = shifted;
    pkt.three_beat = write && (addr[2:0] == 3'd0);
    pkt.root_upd   = write && (bus == root_bus) && (addr == ADDR_W'(PRIM_BUS_OFS));
  end

endmodule

// File: rtl/cfg_beat_sequencer.sv
module cfg_beat_sequencer
  import cfg_tlp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  cfg_pkt_t    pkt_in,
  input  logic        beat_ready,
  output logic        idle,
  output logic        done,
  output logic        upd_root,
  output logic [7:0]  upd_value,
  output logic        beat_valid,
  output logic [63:0] beat_data,
  output logic        beat_sop,
  output logic        beat_eop
);

  typedef enum logic [1:0] {SQ_IDLE, SQ_HEAD, SQ_MID, SQ_LAST} sq_state_e;

  sq_state_e state_q, state_d;
  cfg_pkt_t  pkt_q;
  logic      take;

  assign take = beat_valid && beat_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE: if (load) state_d = SQ_HEAD;
      SQ_HEAD: if (take) state_d = pkt_q.three_beat ? SQ_MID : SQ_LAST;
      SQ_MID:  if (take) state_d = SQ_LAST;
      SQ_LAST: if (take) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pkt_q <= '0;
    else if (load) pkt_q <= pkt_in;
  end

  always_comb begin
    case (state_q)
      SQ_HEAD: beat_data = {pkt_q.dw1, pkt_q.dw0};
      SQ_MID:  beat_data = {32'd0, pkt_q.dw2};
      SQ_LAST: beat_data = pkt_q.three_beat ? {32'd0, pkt_q.data}
                                            : {pkt_q.data, pkt_q.dw2};
      default: beat_data = 64'd0;
    endcase
  end

  assign idle       = (state_q == SQ_IDLE);
  assign beat_valid = !idle;
  assign beat_sop   = (state_q == SQ_HEAD);
  assign beat_eop   = (state_q == SQ_LAST);
  assign done       = take && beat_eop;
  assign upd_root   = pkt_q.root_upd;
  assign upd_value  = pkt_q.data[7:0];

  // R12: a stalled beat keeps its payload and flags
  p_beat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_data)
                                  && $stable(beat_sop) && $stable(beat_eop));

  // R7: every packet opens with a start-flagged beat
  p_sop_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> beat_sop);

  // R12: the end beat is followed by a gap
  p_eop_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_eop |=> !beat_valid);

endmodule

// File: rtl/cfg_tlp_builder.sv
module cfg_tlp_builder
  import cfg_tlp_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter logic [7:0] ROOT_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        link_state,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [7:0]        req_prim_bus,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [63:0]       beat_data,
  output logic              beat_sop,
  output logic              beat_eop,
  output logic              resp_valid,
  output logic [1:0]        resp_status,
  output logic [31:0]       resp_rdata,
  output logic [7:0]        root_bus
);

  logic [1:0]  rst_sync_q;
  logic        rst_n_i;
  cfg_status_e status;
  cfg_pkt_t    pkt;
  logic [3:0]  byte_en;
  logic        accept, load, refuse;
  logic        seq_idle, seq_done, upd_root;
  logic [7:0]  upd_value;
  logic        resp_valid_d;
  logic [1:0]  resp_status_d;
  logic [31:0] resp_rdata_d;
  logic [7:0]  root_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  cfg_access_filter #(.ADDR_W(ADDR_W)) u_filter (
    .bus        (req_bus),
    .devfn      (req_devfn),
    .prim_bus   (req_prim_bus),
    .addr       (req_addr),
    .root_bus   (root_bus),
    .link_state (link_state),
    .status     (status)
  );

  cfg_header_former #(.ADDR_W(ADDR_W)) u_former (
    .bus      (req_bus),
    .devfn    (req_devfn),
    .addr     (req_addr),
    .size     (req_size),
    .write    (req_write),
    .wdata    (req_wdata),
    .root_bus (root_bus),
    .byte_en  (byte_en),
    .pkt      (pkt)
  );

  assign req_ready = seq_idle;
  assign accept    = req_valid && req_ready;
  assign refuse    = (status != ST_SENT);
  assign load      = accept && !refuse;

  cfg_beat_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load       (load),
    .pkt_in     (pkt),
    .beat_ready (beat_ready),
    .idle       (seq_idle),
    .done       (seq_done),
    .upd_root   (upd_root),
    .upd_value  (upd_value),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .beat_sop   (beat_sop),
    .beat_eop   (beat_eop)
  );

  always_comb begin
    resp_valid_d  = 1'b0;
    resp_status_d = ST_SENT;
    resp_rdata_d  = 32'd0;
    if (accept && refuse) begin
      resp_valid_d  = 1'b1;
      resp_status_d = status;
      if (!req_write && (status == ST_NO_DEVICE)) resp_rdata_d = 32'hFFFF_FFFF;
    end else if (seq_done) begin
      resp_valid_d = 1'b1;
    end
  end

  always_comb begin
    root_d = root_bus;
    if (seq_done && upd_root) root_d = upd_value;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      resp_valid  <= 1'b0;
      resp_status <= ST_SENT;
      resp_rdata  <= 32'd0;
      root_bus    <= ROOT_INIT;
    end else begin
      resp_valid  <= resp_valid_d;
      if (resp_valid_d) begin
        resp_status <= resp_status_d;
        resp_rdata  <= resp_rdata_d;
      end
      root_bus    <= root_d;
    end
  end

  // R8: a refused request produces a response and no packet
  p_refuse_no_pkt_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    accept && refuse |=> !beat_valid && resp_valid && (resp_status != 2'd0));

  // R9: beyond the root bus with the link down nothing is reachable
  p_link_down_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    accept && (req_bus != root_bus) && (link_state != LINK_UP_STATE)
    |=> resp_valid && (resp_status == 2'd1) && !beat_valid);

  // R11: the root bus copy only moves after an end beat is taken
  p_root_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(beat_valid && beat_ready && beat_eop) |=> $stable(root_bus));

  // R12: no request is taken while a packet is in flight
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n_i)
    beat_valid |-> !req_ready);

  // R5: a one-byte access enables exactly one byte lane
  p_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_valid && (req_size == 2'd0) |-> ($countones(byte_en) == 1));

endmodule

// File: tb/cfg_tlp_builder_test.sv
`timescale 1ns/100ps
module cfg_tlp_builder_test;

  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [4:0]        link_state;
  logic              req_valid, req_ready, req_write;
  logic [1:0]        req_size;
  logic [7:0]        req_bus, req_devfn, req_prim_bus;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              beat_valid, beat_ready, beat_sop, beat_eop;
  logic [63:0]       beat_data;
  logic              resp_valid;
  logic [1:0]        resp_status;
  logic [31:0]       resp_rdata;
  logic [7:0]        root_bus;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;
  logic [7:0] mroot = 8'h00;
  int  txn = 0;

  always #2.5 clk = ~clk;

  cfg_tlp_builder #(.ADDR_W(ADDR_W), .ROOT_INIT(8'h00)) uut (
    .clk(clk), .rst_n(rst_n), .link_state(link_state),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_prim_bus(req_prim_bus), .req_addr(req_addr), .req_wdata(req_wdata),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_sop(beat_sop), .beat_eop(beat_eop), .resp_valid(resp_valid),
    .resp_status(resp_status), .resp_rdata(resp_rdata), .root_bus(root_bus)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // One request: drive, compare every beat or the refusal, then the response.
  task automatic run_req(input bit wr, input logic [1:0] sz, input logic [7:0] bus,
                         input logic [7:0] devfn, input logic [7:0] prim,
                         input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                         input logic [4:0] ls);
    logic [3:0]  be;
    logic [31:0] msk, dat, dw0, dw1, dw2;
    logic [7:0]  fmt;
    logic [1:0]  code;
    logic [63:0] eb [3];
    int          nb;
    string       rtag;
    int          k, cyc;
    bit          rdy;
    logic [7:0]  root_after;

    // expected status
    if (bus == mroot && devfn == 8'd0 && addr == 12'h010) begin code = 2'd2; rtag = "R8"; end
    else if (bus != mroot && ls != 5'h0F) begin code = 2'd1; rtag = "R9"; end
    else if (bus == mroot && devfn[7:3] != 0) begin code = 2'd1; rtag = "R10"; end
    else if (prim == mroot && devfn[7:3] != 0) begin code = 2'd1; rtag = "R10"; end
    else begin code = 2'd0; rtag = "R12"; end

    case (sz)
      2'd0: begin be = 4'(4'b0001 << addr[1:0]); msk = {24'd0, wd[7:0]}; end
      2'd1: begin be = 4'(4'b0011 << addr[1:0]); msk = {16'd0, wd[15:0]}; end
      default: begin be = 4'hF; msk = wd; end
    endcase
    dat = wr ? 32'(msk << (8 * addr[1:0])) : 32'd0;
    fmt = (wr ? 8'h44 : 8'h04) + ((bus != mroot) ? 8'h01 : 8'h00);
    dw0 = {fmt, 24'd1};
    dw1 = {mroot, 8'd0, (wr ? 8'h10 : 8'h1D), 4'd0, be};
    dw2 = {bus, devfn, 4'd0, addr[11:2], 2'b00};
    eb[0] = {dw1, dw0};
    if (wr && addr[2:0] == 3'd0) begin
      nb = 3; eb[1] = {32'd0, dw2}; eb[2] = {32'd0, dat};
    end else begin
      nb = 2; eb[1] = {dat, dw2}; eb[2] = 64'd0;
    end
    root_after = mroot;
    if (code == 2'd0 && wr && bus == mroot && addr == 12'h018) root_after = dat[7:0];

    req_write = wr; req_size = sz; req_bus = bus; req_devfn = devfn;
    req_prim_bus = prim; req_addr = addr; req_wdata = wd; link_state = ls;
    req_valid = 1'b1;
    check(req_ready == 1'b1, "R12 ready before request", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;

    if (code != 2'd0) begin
      check(beat_valid == 1'b0, rtag, 64'(beat_valid), 64'd0);
      check(resp_valid == 1'b1, rtag, 64'(resp_valid), 64'd1);
      check(resp_status == code, rtag, 64'(resp_status), 64'(code));
      check(resp_rdata == ((!wr && code == 2'd1) ? 32'hFFFF_FFFF : 32'd0), rtag,
            64'(resp_rdata), (!wr && code == 2'd1) ? 64'hFFFF_FFFF : 64'd0);
      @(posedge clk); #1;
      check(root_bus == mroot, "R11 unchanged after refusal", 64'(root_bus), 64'(mroot));
      check(resp_valid == 1'b0, "R12 pulse length", 64'(resp_valid), 64'd0);
    end else begin
      k = 0; cyc = 0;
      while (k < nb && cyc < 40) begin
        case (txn % 3)
          0: rdy = 1'b1;
          1: rdy = (cyc % 2) == 1;
          default: rdy = (cyc % 3) == 2;
        endcase
        beat_ready = rdy;
        check(beat_valid == 1'b1, "R12 beat present", 64'(beat_valid), 64'd1);
        check(resp_valid == 1'b0, "R12 no early response", 64'(resp_valid), 64'd0);
        check(beat_data[31:0] == eb[k][31:0], (k == 0) ? "R2 low half" : "R4 low half",
              64'(beat_data[31:0]), 64'(eb[k][31:0]));
        check(beat_data[63:32] == eb[k][63:32], (k == 0) ? "R3 high half" : "R5 high half",
              64'(beat_data[63:32]), 64'(eb[k][63:32]));
        check({beat_sop, beat_eop} == {(k == 0), (k == nb - 1)},
              (nb == 3) ? "R6 flags" : "R7 flags",
              64'({beat_sop, beat_eop}), 64'({(k == 0), (k == nb - 1)}));
        @(posedge clk); #1;
        if (rdy) k++;
        cyc++;
      end
      beat_ready = 1'b0;
      check(resp_valid == 1'b1, "R12 response after end beat", 64'(resp_valid), 64'd1);
      check(resp_status == 2'd0, "R12 sent status", 64'(resp_status), 64'd0);
      check(req_ready == 1'b1 && beat_valid == 1'b0, "R12 idle after packet",
            64'({req_ready, beat_valid}), 64'b10);
      check(root_bus == root_after, "R11 root bus", 64'(root_bus), 64'(root_after));
      mroot = root_after;
      @(posedge clk); #1;
    end
    txn++;
  endtask

  initial begin
    logic [7:0] b, df, pb;
    logic [4:0] ls;
    rst_n = 1'b0; req_valid = 1'b0; beat_ready = 1'b0; req_write = 1'b0;
    req_size = 2'd0; req_bus = 8'd0; req_devfn = 8'd0; req_prim_bus = 8'd0;
    req_addr = '0; req_wdata = 32'd0; link_state = 5'h0F;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    check(beat_valid == 1'b0, "R1 beat_valid", 64'(beat_valid), 64'd0);
    check(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
    check(root_bus == 8'h00, "R1 root bus", 64'(root_bus), 64'd0);

    for (int v = 0; v < 6; v++)
      for (int wr = 0; wr < 2; wr++)
        for (int sz = 0; sz < 4; sz++)
          for (int a = 0; a < 34; a++) begin
            logic [ADDR_W-1:0] ad;
            ad = (a < 32) ? ADDR_W'(a) : ((a == 32) ? 12'hFF8 : 12'h7FD);
            ls = 5'h0F;
            case (v)
              0: begin b = mroot;        df = 8'h00; pb = mroot + 8'd3; end
              1: begin b = mroot;        df = 8'h0A; pb = mroot + 8'd3; end
              2: begin b = mroot + 8'd1; df = 8'h03; pb = mroot; end
              3: begin b = mroot + 8'd1; df = 8'h11; pb = mroot; end
              4: begin b = mroot + 8'd5; df = 8'h19; pb = mroot + 8'd1; end
              default: begin b = mroot + 8'd2; df = 8'h00; pb = mroot; ls = 5'h0E; end
            endcase
            run_req(wr[0], sz[1:0], b, df, pb, ad,
                    {8'hC3, 8'(a * 7), 8'hA5, 8'(8'h20 + sz)}, ls);
          end
    // R9 link state with an unrelated upper bit
    run_req(1'b0, 2'd2, mroot + 8'd9, 8'h00, mroot + 8'd4, 12'h000, 32'd0, 5'h1F);
    // R11 write to the primary bus register with a distinct value, then use it
    run_req(1'b1, 2'd2, mroot, 8'h00, 8'h00, 12'h018, 32'h0000_0042, 5'h0F);
    run_req(1'b0, 2'd2, 8'h42, 8'h00, 8'h00, 12'h004, 32'd0, 5'h00);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule